// File: doc/BRIEF.md
# Single-Operand Byte Operation Unit

This unit performs the one-operand byte operations of an 8-bit microcontroller core: decrement, decimal adjust, complement, left and right rotates (with and without carry), clear, arithmetic and logical right shifts, and nibble swap. A separate unit handles two-operand arithmetic and logic. Operand fetch, register addressing and instruction decoding are done elsewhere.

The decoder gives the unit an operand byte, a 4-bit operation code and the current flag bits. The operation code is the upper nibble of the opcode, passed through unchanged. The unit computes the result in one combinational step and registers it, so the result, the updated flags and a write-enable appear one clock after the request. The core's final execution state for these instructions then commits the registered values.

The flag vector is 6 bits wide. Bit 0 is carry C, bit 1 is zero Z, bit 2 is sign S, bit 3 is overflow V, bit 4 is the decimal-adjust direction D and bit 5 is half-carry H.

Top module: `unary_logic_unit`

## Requirements
- R1: The operation codes are 0x3 decrement, 0x4 decimal adjust, 0x5 logical shift right, 0x6 complement, 0x9 rotate left, 0xB clear, 0xC rotate right through carry, 0xD arithmetic shift right, 0xE rotate right and 0xF swap. These codes raise `wr_en`. Any other code leaves `wr_en` low, returns the operand unchanged as the result and passes the flags through unchanged.
- R2: A request with `in_valid` high appears on the outputs after the next rising clock edge. After a cycle with `in_valid` low, `wr_en` is 0 and `result` and `flags_out` keep their previous values.
- R3: The flag bits are C=bit0, Z=bit1, S=bit2, V=bit3, D=bit4 and H=bit5. No operation changes D or H.
- R4: Decrement returns operand-1 modulo 256. V is set exactly when the operand is 0x80, and C is kept.
- R5: Decimal adjust applies a correction of 0x06 and/or 0x60. When D=0 (after an addition), the low correction applies if H=1 or the low nibble is above 9, the high correction applies if C=1 or the operand is above 0x99, and the corrections are added. When D=1 (after a subtraction), the low correction follows H, the high correction follows C, and the corrections are subtracted. The output C is 1 when the high correction is applied and 0 otherwise. V is kept.
- R6: Complement returns the bitwise inverse of the operand, clears V and keeps C.
- R7: Rotate left moves bit 7 into bit 0 and into C. Rotate right moves bit 0 into bit 7 and into C. Rotate right through carry puts the old C in bit 7 and bit 0 in C. V is kept.
- R8: Arithmetic shift right keeps bit 7, logical shift right fills bit 7 with 0, and both move bit 0 into C. V is kept.
- R9: Swap exchanges the two nibbles and keeps C and V.
- R10: Clear returns 0x00 and leaves all six flags unchanged.
- R11: For every implemented operation except clear, Z is 1 exactly when the result is 0x00, and S equals bit 7 of the result.
- R12: While `rst_n` is low, `result`, `flags_out` and `wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for this cycle |
| op | input | 4 | Operation code (opcode upper nibble) |
| operand | input | 8 | Operand byte |
| flags_in | input | 6 | Current flags {H,D,V,S,Z,C} |
| result | output | 8 | Registered result byte |
| flags_out | output | 6 | Registered updated flags |
| wr_en | output | 1 | Commit strobe for result and flags |

## Verification
The assertions assume that `op`, `operand` and `flags_in` are defined in every cycle where `in_valid` is high. They also assume that reset is held for at least one rising edge before the first request. The bench drives all inputs only on falling edges and keeps them defined throughout. It issues every request only after reset is released. It sweeps all 16 codes over all 256 operands and all eight C/D/H combinations. It inserts idle cycles at intervals to exercise the hold behaviour.

// File: rtl/unary_logic_unit.sv
module unary_logic_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [3:0] op,
  input  logic [7:0] operand,
  input  logic [5:0] flags_in,
  output logic [7:0] result,
  output logic [5:0] flags_out,
  output logic       wr_en
);

  localparam logic [3:0] OP_DEC  = 4'h3;
  localparam logic [3:0] OP_DA   = 4'h4;
  localparam logic [3:0] OP_SRL  = 4'h5;
  localparam logic [3:0] OP_COM  = 4'h6;
  localparam logic [3:0] OP_RL   = 4'h9;
  localparam logic [3:0] OP_CLR  = 4'hB;
  localparam logic [3:0] OP_RRC  = 4'hC;
  localparam logic [3:0] OP_SRA  = 4'hD;
  localparam logic [3:0] OP_RR   = 4'hE;
  localparam logic [3:0] OP_SWAP = 4'hF;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FS = 2;
  localparam int FV = 3;
  localparam int FD = 4;
  localparam int FH = 5;

  logic       c_in, d_in, h_in;
  logic       lo_fix, hi_fix;
  logic [7:0] corr, da_res;
  logic [7:0] nxt_res;
  logic       nxt_c, nxt_v, hit;
  logic [5:0] nxt_flags;

  assign c_in = flags_in[FC];
  assign d_in = flags_in[FD];
  assign h_in = flags_in[FH];

  assign lo_fix = d_in ? h_in : (h_in | (operand[3:0] > 4'd9));
  assign hi_fix = d_in ? c_in : (c_in | (operand > 8'h99));
  assign corr   = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
  assign da_res = d_in ? operand - corr : operand + corr;

  always_comb begin
    nxt_res = operand;
    nxt_c   = c_in;
    nxt_v   = flags_in[FV];
    hit     = 1'b1;
    case (op)
      OP_DEC: begin
        nxt_res = operand - 8'd1;
        nxt_v   = (operand == 8'h80);
      end
      OP_DA: begin
        nxt_res = da_res;
        nxt_c   = hi_fix;
      end
      OP_SRL: begin
        nxt_res = {1'b0, operand[7:1]};
        nxt_c   = operand[0];
      end
      OP_COM: begin
        nxt_res = ~operand;
        nxt_v   = 1'b0;
      end
      OP_RL: begin
        nxt_res = {operand[6:0], operand[7]};
        nxt_c   = operand[7];
      end
      OP_CLR:  nxt_res = 8'h00;
      OP_RRC: begin
        nxt_res = {c_in, operand[7:1]};
        nxt_c   = operand[0];
      end
      OP_SRA: begin
        nxt_res = {operand[7], operand[7:1]};
        nxt_c   = operand[0];
      end
      OP_RR: begin
        nxt_res = {operand[0], operand[7:1]};
        nxt_c   = operand[0];
      end
      OP_SWAP: nxt_res = {operand[3:0], operand[7:4]};
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    nxt_flags = flags_in;
    if (hit && op != OP_CLR) begin
      nxt_flags[FC] = nxt_c;
      nxt_flags[FZ] = (nxt_res == 8'h00);
      nxt_flags[FS] = nxt_res[7];
      nxt_flags[FV] = nxt_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= 8'h00;
      flags_out <= 6'h00;
      wr_en     <= 1'b0;
    end else begin
      wr_en <= in_valid & hit;
      if (in_valid) begin
        result    <= nxt_res;
        flags_out <= nxt_flags;
      end
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && $stable(result) && $stable(flags_out))); // R2

  AST_DH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flags_out[5:4] == $past(flags_in[5:4]))); // R3

  AST_DEC_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DEC) |=> (flags_out[FV] == (result == 8'h7F))); // R4

  AST_COM_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_COM) |=> !flags_out[FV]); // R6

  AST_CLR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLR) |=> (result == 8'h00 && flags_out == $past(flags_in) && wr_en)); // R10

  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && op != OP_CLR) |=>
      (flags_out[FZ] == (result == 8'h00) && flags_out[FS] == result[7])); // R11

  AST_UNKNOWN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit) |=> (!wr_en && result == $past(operand) && flags_out == $past(flags_in))); // R1

endmodule

// File: tb/unary_logic_unit_tb.sv
module unary_logic_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = 4'h0;
  logic [7:0] operand = 8'h00;
  logic [5:0] flags_in = 6'h00;
  logic [7:0] result;
  logic [5:0] flags_out;
  logic       wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    exp_res = 0;
  int    exp_flags = 0;
  bit    exp_wr = 1'b0;
  bit    have_exp = 1'b0;
  string exp_tag = "R12";

  always #2 clk = ~clk;

  unary_logic_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
    .flags_in(flags_in), .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  function automatic string tag_of(int code);
    case (code)
      3:  return "R4 R3 R11";
      4:  return "R5 R3 R11";
      6:  return "R6 R3 R11";
      9, 12, 14: return "R7 R3 R11";
      5, 13: return "R8 R3 R11";
      15: return "R9 R3 R11";
      11: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input int code, input int a, input int f, output int r, output int fo, output bit w);
    int c, d, h, v, lo, hi, cr;
    bit touch;
    c = f & 1; v = (f >> 3) & 1; d = (f >> 4) & 1; h = (f >> 5) & 1;
    r = a; w = 1'b1; touch = 1'b1;
    case (code)
      3:  begin r = (a + 255) % 256; v = (a == 128) ? 1 : 0; end
      4:  begin
            if (d == 1) begin lo = h; hi = c; end
            else begin
              lo = (h == 1 || (a % 16) > 9) ? 1 : 0;
              hi = (c == 1 || a > 153) ? 1 : 0;
            end
            cr = lo * 6 + hi * 96;
            r = (d == 1) ? (a - cr + 256) % 256 : (a + cr) % 256;
            c = hi;
          end
      5:  begin r = a / 2; c = a % 2; end
      6:  begin r = 255 - a; v = 0; end
      9:  begin r = (a * 2) % 256 + a / 128; c = a / 128; end
      11: begin r = 0; touch = 1'b0; end
      12: begin r = c * 128 + a / 2; c = a % 2; end
      13: begin r = (a / 128) * 128 + a / 2; c = a % 2; end
      14: begin r = (a % 2) * 128 + a / 2; c = a % 2; end
      15: r = (a % 16) * 16 + a / 16;
      default: begin w = 1'b0; touch = 1'b0; end
    endcase
    if (touch)
      fo = c + ((r == 0) ? 2 : 0) + ((r >= 128) ? 4 : 0) + v * 8 + d * 16 + h * 32;
    else
      fo = f;
  endtask

  task automatic compare();
    checks++;
    if (result !== 8'(exp_res) || flags_out !== 6'(exp_flags) || wr_en !== exp_wr) begin
      errors++;
      $display("FAIL %s: got res=%h flags=%b wr=%b, expected res=%h flags=%b wr=%b",
               exp_tag, result, flags_out, wr_en, 8'(exp_res), 6'(exp_flags), exp_wr);
    end
  endtask

  task automatic drive(input bit v, input int code, input int a, input int f);
    int r, fo;
    bit w;
    @(negedge clk);
    if (have_exp) compare();
    in_valid = v; op = 4'(code); operand = 8'(a); flags_in = 6'(f);
    if (v) begin
      model(code, a, f, r, fo, w);
      exp_res = r; exp_flags = fo; exp_wr = w; exp_tag = tag_of(code);
    end else begin
      exp_wr = 1'b0; exp_tag = "R2 idle hold";
    end
    have_exp = 1'b1;
  endtask

  initial begin
    int n;
    n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_tag = "R12 reset";
    compare();
    rst_n = 1'b1;
    for (int code = 0; code < 16; code++) begin
      for (int a = 0; a < 256; a++) begin
        for (int cdh = 0; cdh < 8; cdh++) begin
          int f;
          f = (cdh & 1) + ((cdh >> 1) & 1) * 16 + ((cdh >> 2) & 1) * 32
            + ((a >> 1) & 1) * 2 + ((a >> 2) & 1) * 4 + ((a >> 3) & 1) * 8;
          drive(1'b1, code, a, f);
          n++;
          if (n % 37 == 0) drive(1'b0, (code + 5) % 16, 255 - a, 63 - f);
        end
      end
    end
    drive(1'b0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule